// File: doc/BRIEF.md
# LED Driver Serial Control Logic

This block is the digital control core of a sixteen-channel constant-current LED driver. A host shifts words in on a serial data line, most significant bit first, with one bit taken on each rising edge of a serial clock. A rising edge on a latch strobe then copies the shift register into one of two latches. A select input picks which one: the on/off latch, which holds one enable bit per channel, or the function-control latch, which holds the blank-pin mode bit and the power-save enable bit. The analog current sinks, the reference and the fault comparators lie outside this block. The channel enables leave it as plain logic levels.

The blank input has two meanings. In output-enable mode, blank high turns every channel off, and blank low lets the on/off latch drive the channels. In tap-select mode, blank chooses where the serial output is taken from the shift register. Blank low takes bit 7, for chaining eight-channel parts. Blank high takes bit 15, for chaining sixteen-channel parts. A power-save state is entered by a strobe that leaves the on/off latch all zero while power save is enabled. The next serial-clock rising edge leaves that state.

All inputs are assumed to be synchronous to the system clock `clk`. The block detects serial-clock and strobe edges by comparing each input with its value at the previous `clk` edge.

Top module: `led_serial_ctl`

## Requirements
- R1: After synchronous active-low reset, all channel enables are 0, the power-save flag is 0, both latches are cleared, and the block is in tap-select mode.
- R2: On each rising edge of `sclk_i`, the shift register moves one place toward bit 15 and takes `sdi_i` into bit 0. After sixteen edges it holds the sixteen bits sent, with the first bit in bit 15.
- R3: On a rising edge of `lat_i`, the shift register is copied into the on/off latch when `lat_sel_i`=0, and into the function-control latch when `lat_sel_i`=1. The other latch keeps its contents.
- R4: Function-control bit 9 selects the blank-pin mode: 1 gives output-enable mode and 0 gives tap-select mode. The mode changes only when the function-control latch is written.
- R5: In output-enable mode, `ch_en_o` equals the on/off latch when `blank_i`=0, and is all zero when `blank_i`=1. `sout_o` is shift-register bit 15 whatever the level of `blank_i`.
- R6: In tap-select mode, `ch_en_o` equals the on/off latch whatever the level of `blank_i`. `sout_o` is shift-register bit 7 when `blank_i`=0, and bit 15 when `blank_i`=1.
- R7: Function-control bit 8 is the power-save enable. Power save is entered on a strobe that leaves the on/off latch all zero while bit 8 is 1, with bit 8 taken as its value after the strobe. This covers a strobe that writes zeros into the on/off latch, and a strobe that writes the function-control latch while the on/off latch is already zero. No other strobe enters power save.
- R8: Power save ends on the next rising edge of `sclk_i`. If that edge comes in the same cycle as an entering strobe, the exit wins and the flag stays 0.
- R9: While in power save, every channel enable is 0, even if a strobe loads non-zero on/off data. When power save ends, the channels follow the latched data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock; the shift register steps on its rising edge |
| sdi_i | input | 1 | Serial data in, most significant bit first |
| lat_i | input | 1 | Latch strobe; acts on its rising edge |
| lat_sel_i | input | 1 | Strobe target: 0 selects the on/off latch, 1 selects the function-control latch |
| blank_i | input | 1 | Output blank in output-enable mode; serial-out tap select in tap-select mode |
| ch_en_o | output | 16 | Channel enables |
| sout_o | output | 1 | Serial output for daisy-chaining |
| psave_o | output | 1 | High while in power save |

## Verification
Each edge of `sclk_i` or `lat_i` is sampled by one register, so its effect appears after the first `clk` rising edge that sees the new level. Blank, channel-enable and tap selection are combinational from state, so a change on `blank_i` shows at once. The bench changes inputs on falling clock edges and reads outputs on the next falling edge. Every latched result is therefore due exactly one rising edge after its stimulus, and every blank-driven result is due in the same half cycle. The sweeps compute expected taps and enables as bit-selects and shifts of the words sent.

// File: rtl/led_ctl_pkg.sv
// Package: shared constants and types for the LED driver serial control logic.
// Assumes sixteen channels, a function-control word as wide as the shift register,
// and fixed positions for the mode bit and the power-save enable bit.
package led_ctl_pkg;
    localparam int unsigned CH_COUNT  = 16;
    localparam int unsigned MODE_POS  = 9;
    localparam int unsigned PSEN_POS  = 8;

    typedef enum logic {
        BLK_TAP_SEL = 1'b0,
        BLK_OUT_EN  = 1'b1
    } blank_mode_e;
endpackage

// File: rtl/led_edge_detect.sv
// Module: rising-edge detectors for a group of inputs that are synchronous to clk.
// Each output pulses for one clk cycle in the first cycle that sees its input high
// after a low sample. Assumes the inputs are already synchronous to clk.
module led_edge_detect #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Keep the previous sample of each input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= sig_i[g];
        end
        // Flag a low-to-high change.
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/led_shift_reg.sv
// Module: common serial shift register, filled most significant bit first.
// Steps by one place when step_i is high; bit 0 takes the serial input.
// Assumes step_i is a single-cycle pulse for each serial clock edge.
module led_shift_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             sdi_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] sreg_q;

    // Shift toward the top bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      sreg_q <= '0;
        else if (step_i) sreg_q <= {sreg_q[WIDTH-2:0], sdi_i};
    end

    assign data_o = sreg_q;

    // R2: a step brings in the serial bit and moves the old contents up.
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (sreg_q[0] == $past(sdi_i)) &&
                   (sreg_q[WIDTH-1:1] == $past(sreg_q[WIDTH-2:0])));
endmodule

// File: rtl/led_latch_bank.sv
// Module: on/off data latch and function-control latch.
// A strobe pulse copies the shift register into the latch chosen by sel_i
// (0 = on/off, 1 = function control). Only the control fields this block uses
// are stored. Assumes strobe_i is a single-cycle pulse.
module led_latch_bank #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned MODE_BIT = 9,
    parameter int unsigned PSEN_BIT = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_i,
    input  logic                     sel_i,
    input  logic [WIDTH-1:0]         shift_i,
    output logic [WIDTH-1:0]         onoff_o,
    output led_ctl_pkg::blank_mode_e mode_o,
    output logic                     psen_o
);
    import led_ctl_pkg::*;

    logic [WIDTH-1:0] onoff_q;
    blank_mode_e      mode_q;
    logic             psen_q;

    // Load the on/off latch on a strobe aimed at it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 onoff_q <= '0;
        else if (strobe_i && !sel_i) onoff_q <= shift_i;
    end

    // Load the control fields on a strobe aimed at the control latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BLK_TAP_SEL;
            psen_q <= 1'b0;
        end else if (strobe_i && sel_i) begin
            mode_q <= blank_mode_e'(shift_i[MODE_BIT]);
            psen_q <= shift_i[PSEN_BIT];
        end
    end

    assign onoff_o = onoff_q;
    assign mode_o  = mode_q;
    assign psen_o  = psen_q;

    // R3: the on/off latch holds unless a strobe targets it.
    a_r3_onoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && !sel_i) |=> $stable(onoff_q));
    // R4: the blank mode holds unless the control latch is written.
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && sel_i) |=> $stable(mode_q) && $stable(psen_q));
endmodule

// File: rtl/led_power_save.sv
// Module: power-save state.
// Enters on a strobe that leaves the on/off latch all zero while the power-save
// enable (its value after the strobe) is set. Leaves on a serial clock rising edge;
// the exit wins over an entry in the same cycle.
module led_power_save #(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned PSEN_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             sel_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] shift_i,
    input  logic [WIDTH-1:0] onoff_i,
    input  logic             psen_i,
    output logic             save_o
);
    logic save_q;
    logic psen_next;
    logic zero_next;
    logic enter;

    // Work out the enable and on/off state as they will be after this strobe.
    always_comb begin
        psen_next = sel_i ? shift_i[PSEN_BIT] : psen_i;
        zero_next = sel_i ? (onoff_i == '0) : (shift_i == '0);
        enter     = strobe_i && psen_next && zero_next;
    end

    // Hold the power-save flag; a serial clock edge clears it first.
    always_ff @(posedge clk) begin
        if (!rst_n)      save_q <= 1'b0;
        else if (step_i) save_q <= 1'b0;
        else if (enter)  save_q <= 1'b1;
    end

    assign save_o = save_q;

    // R8: a serial clock edge always leaves power save.
    a_r8_exit_on_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> !save_q);
    // R7: power save begins only on a strobe.
    a_r7_entry_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_q) |-> $past(strobe_i));
endmodule

// File: rtl/led_serial_ctl.sv
// Module: top of the LED driver serial control logic.
// Joins edge detection, the shift register, the latch bank and the power-save
// state, and drives the channel enables and the serial-out tap from the
// blank-pin mode. Assumes all inputs are synchronous to clk.
module led_serial_ctl #(
    parameter int unsigned N_CH     = led_ctl_pkg::CH_COUNT,
    parameter int unsigned MODE_BIT = led_ctl_pkg::MODE_POS,
    parameter int unsigned PSEN_BIT = led_ctl_pkg::PSEN_POS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdi_i,
    input  logic            lat_i,
    input  logic            lat_sel_i,
    input  logic            blank_i,
    output logic [N_CH-1:0] ch_en_o,
    output logic            sout_o,
    output logic            psave_o
);
    import led_ctl_pkg::*;

    localparam int unsigned TAP_LO = N_CH / 2 - 1;
    localparam int unsigned TAP_HI = N_CH - 1;

    logic [1:0]      rise;
    logic            sclk_rise;
    logic            lat_rise;
    logic [N_CH-1:0] shift_q;
    logic [N_CH-1:0] onoff_q;
    blank_mode_e     mode_q;
    logic            psen_q;
    logic            save_q;

    led_edge_detect #(.WIDTH(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({lat_i, sclk_i}),
        .rise_o (rise)
    );
    assign sclk_rise = rise[0];
    assign lat_rise  = rise[1];

    led_shift_reg #(.WIDTH(N_CH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (sclk_rise),
        .sdi_i  (sdi_i),
        .data_o (shift_q)
    );

    led_latch_bank #(.WIDTH(N_CH), .MODE_BIT(MODE_BIT), .PSEN_BIT(PSEN_BIT)) u_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (lat_rise),
        .sel_i    (lat_sel_i),
        .shift_i  (shift_q),
        .onoff_o  (onoff_q),
        .mode_o   (mode_q),
        .psen_o   (psen_q)
    );

    led_power_save #(.WIDTH(N_CH), .PSEN_BIT(PSEN_BIT)) u_psave (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (lat_rise),
        .sel_i    (lat_sel_i),
        .step_i   (sclk_rise),
        .shift_i  (shift_q),
        .onoff_i  (onoff_q),
        .psen_i   (psen_q),
        .save_o   (save_q)
    );

    // Gate the channel enables by power save and, in output-enable mode, by blank.
    always_comb begin
        if (save_q || (mode_q == BLK_OUT_EN && blank_i)) ch_en_o = '0;
        else                                             ch_en_o = onoff_q;
    end

    // Pick the serial-out tap: the top bit, or the middle bit in tap-select mode with blank low.
    always_comb begin
        if (mode_q == BLK_TAP_SEL && !blank_i) sout_o = shift_q[TAP_LO];
        else                                   sout_o = shift_q[TAP_HI];
    end

    assign psave_o = save_q;

    // R5: with output-enable mode and blank high, no channel is driven.
    a_r5_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BLK_OUT_EN && blank_i) |-> (ch_en_o == '0));
    // R9: no channel is driven while the power-save latch is set.
    a_r9_save_dark: assert property (@(posedge clk) disable iff (!rst_n)
        psave_o |-> (ch_en_o == '0));
endmodule

// File: tb/led_serial_ctl_test.sv
`timescale 1ns/1ps
module led_serial_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, lat = 1'b0, lat_sel = 1'b0, blank = 1'b0;
    logic [15:0] ch_en;
    logic        sout, psave;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    led_serial_ctl uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .lat_i(lat),
        .lat_sel_i(lat_sel), .blank_i(blank), .ch_en_o(ch_en), .sout_o(sout), .psave_o(psave)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sclk_pulse(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) sclk_pulse(w[i]);
    endtask

    task automatic strobe(input logic sel);
        @(negedge clk); lat_sel = sel; lat = 1'b1;
        @(negedge clk); lat = 1'b0;
    endtask

    task automatic set_blank(input logic b);
        blank = b; #0.5;
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ch_en, 16'h0000, "R1 ch_en after reset");
        check({15'd0, psave}, 16'h0000, "R1 psave after reset");
        check({15'd0, sout}, 16'h0000, "R1 sout after reset");
        // R1/R6: default tap-select mode, bit 7 with blank low
        shift_word(16'h0080);
        set_blank(1'b0); check({15'd0, sout}, 16'h0001, "R1 default mode taps bit 7");
        set_blank(1'b1); check({15'd0, sout}, 16'h0000, "R6 blank high taps bit 15");

        // R6: tap sweep over single-bit words
        for (int k = 0; k < 16; k++) begin
            w = 16'h0001 << k;
            shift_word(w);
            set_blank(1'b0); check({15'd0, sout}, {15'd0, w[7]}, "R6 tap bit 7 sweep");
            set_blank(1'b1); check({15'd0, sout}, {15'd0, w[15]}, "R6 tap bit 15 sweep");
        end

        // R2: MSB-first order seen through the top tap while shifting on
        w = 16'hA5C3;
        shift_word(w);
        set_blank(1'b1);
        for (int j = 0; j < 16; j++) begin
            check({15'd0, sout}, {15'd0, w[15-j]}, "R2 shift order");
            sclk_pulse(1'b0);
        end

        // R3/R6: on/off latch sweep, channels follow data under either blank level
        for (int k = 0; k < 16; k++) begin
            w = (16'h0001 << k) | (16'h8000 >> ((k + 5) % 16));
            shift_word(w);
            strobe(1'b0);
            set_blank(1'b0); check(ch_en, w, "R3 on/off load, R6 blank low");
            set_blank(1'b1); check(ch_en, w, "R6 blank high ignored for channels");
        end
        // w now holds the last on/off data
        // R3/R4: control write to enable mode leaves on/off untouched
        shift_word(16'h0200);
        strobe(1'b1);
        set_blank(1'b0); check(ch_en, w, "R3 control write keeps on/off");
        check({15'd0, psave}, 16'h0000, "R7 no save with enable bit clear");
        set_blank(1'b1); check(ch_en, 16'h0000, "R5 blank high forces off");
        // R5: top tap regardless of blank
        shift_word(16'h8000);
        set_blank(1'b0); check({15'd0, sout}, 16'h0001, "R5 sout bit 15 with blank low");
        set_blank(1'b1); check({15'd0, sout}, 16'h0001, "R5 sout bit 15 with blank high");
        // R4: on/off write does not change mode
        strobe(1'b0);
        set_blank(1'b1); check(ch_en, 16'h0000, "R4 mode held over on/off write");
        set_blank(1'b0); check(ch_en, 16'h8000, "R5 blank low shows on/off");
        // R4: back to tap-select mode
        shift_word(16'h0000);
        strobe(1'b1);
        set_blank(1'b1); check(ch_en, 16'h8000, "R4 tap-select mode restored");
        // R7: zero on/off write with enable clear does nothing
        strobe(1'b0);
        check({15'd0, psave}, 16'h0000, "R7 zero write without enable");

        // R7: enable set while on/off non-zero: no entry
        shift_word(16'h8000); strobe(1'b0);
        shift_word(16'h0100); strobe(1'b1);
        check({15'd0, psave}, 16'h0000, "R7 enable with on/off non-zero");
        // R7: zero on/off write with enable set enters
        shift_word(16'h0000); strobe(1'b0);
        check({15'd0, psave}, 16'h0001, "R7 zero on/off write enters");
        check(ch_en, 16'h0000, "R9 dark in save");
        // R8: next serial clock exits
        sclk_pulse(1'b0);
        check({15'd0, psave}, 16'h0000, "R8 exit on serial clock");
        // R7: control write while on/off zero enters
        shift_word(16'h0103); strobe(1'b1);
        check({15'd0, psave}, 16'h0001, "R7 control write with zero on/off enters");
        // R9: non-zero on/off loaded during save stays dark
        strobe(1'b0);
        set_blank(1'b0);
        check({15'd0, psave}, 16'h0001, "R9 save held over non-zero load");
        check(ch_en, 16'h0000, "R9 channels dark in save");
        sclk_pulse(1'b0);
        check({15'd0, psave}, 16'h0000, "R8 exit after load");
        check(ch_en, 16'h0103, "R9 channels return after exit");
        // R8: exit wins over a same-cycle entering strobe
        shift_word(16'h0000);
        @(negedge clk); lat_sel = 1'b0; lat = 1'b1; sclk = 1'b1; sdi = 1'b0;
        @(negedge clk); lat = 1'b0; sclk = 1'b0;
        check({15'd0, psave}, 16'h0000, "R8 exit wins over same-cycle entry");
        check(ch_en, 16'h0000, "R3 zero data latched with simultaneous edge");
        // R1: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        shift_word(16'h0080);
        set_blank(1'b0); check({15'd0, sout}, 16'h0001, "R1 reset restores tap-select mode");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule